// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a single-ported pipelined synchronous SRAM with a common data path. The address and all control inputs are captured on the rising clock edge. An access is opened by either of two address strobes. The controller strobe can read or write on its own edge. The processor strobe always reads on its own edge. Later beats of the access are driven by an advance input. This input either steps a two-bit wrapping counter on the low address bits or, when held inactive, repeats the current beat.

Writes either cover the whole word or a chosen set of byte lanes. Read data leaves through one output register, and an asynchronous output enable gates the bus drivers. The pad-level tri-state buffer sits outside the block, which presents read data, write data and a drive-enable on separate ports. A sleep input suspends all accesses and clears the read pipeline. The default geometry is 1K words of 32 bits in four lanes. Word count, word width and lane count are parameters, and a 64K-word array is obtained by setting the address width to 16.

Top module: `burst_sram`

## Requirements
- R1: When `gwN` is low, a write cycle stores all lanes. When `gwN` is high and `bweN` is low, a write cycle stores exactly the lanes whose `bwN` bit is low, with bit i selecting data bits [8i+7:8i]. The other lanes keep their old contents. When both are high, the cycle is a read.
- R2: Starting an access loads the two low address bits into the burst counter. On each later clock with `advN` low and no strobe active, those bits step by one modulo 4, and the upper bits stay fixed. A burst that starts at a low value of 2 visits 2, 3, 0, 1.
- R3: A read whose address is captured at rising edge N presents that word on `dqOut` after edge N+1, with `dqOe` high if `oeN` is low.
- R4: While `oeN` is high, `dqOe` is low. This holds at once, without waiting for a clock edge.
- R5: An access opened by `adspN` (with `adscN` high and `ceN` low) reads on that edge even when write enables are asserted. Writes happen only on the following continuation clocks.
- R6: A clock with `advN` high, no strobe and an open access repeats the current address, and it reads or writes according to the write enables.
- R7: A low `adscN` loads a new base address even in mid-burst, and it wins over `adspN` when both are low. A low `adspN` is ignored while `ceN` is high.
- R8: A low `adscN` with `ceN` high closes the access. No later clock reads or writes until a new strobe opens one, and the output turns off two edges later.
- R9: After a write cycle, `dqOe` stays low until a read cycle has passed through the pipeline.
- R10: A clock with `zz` high performs no access, closes any burst and empties the read pipeline. While `zz` is high, and after it falls, `dqOe` stays low until a new read completes.
- R11: After reset, `dqOe` is low and no access is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of control and pipeline state |
| addr | input | ADDR_W | Word address, sampled when a strobe opens an access |
| ceN | input | 1 | Chip enable, active low |
| adscN | input | 1 | Controller address strobe, active low |
| adspN | input | 1 | Processor address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| gwN | input | 1 | Global (full-word) write, active low |
| bweN | input | 1 | Byte-write enable, active low |
| bwN | input | LANES | Per-lane write enables, active low, bit i for lane i |
| oeN | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Sleep, active high |
| dqIn | input | DATA_W | Write data from the bus |
| dqOut | output | DATA_W | Registered read data |
| dqOe | output | 1 | Bus drive-enable for the pad buffer |

## Verification
The bench aims at four corner cases. The first is a burst that starts at a low value of 2, where a counter that carried into the upper bits would write outside the block of four. The second is a processor-strobe start with write enables asserted, where a decoder that allowed the write would corrupt the word the cycle should only read. The third is both strobes low at once, plus the processor strobe with the chip disabled, where the wrong priority would load a stale base or open a phantom access. The fourth is sleep or a deselect in the middle of a read stream, where a pipeline that is not cleared would drive stale data once sleep ends. Partial byte writes are read back lane by lane, and a constrained random phase checks every cycle against a reference array.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  localparam int BEAT_W = 2;

  // Per-edge command from control to datapath
  typedef struct packed {
    logic              rd;     // read the operation address this edge
    logic              wr;     // write the lanes given alongside
    logic              load;   // new base captured from the address pins
    logic              flush;  // sleep: empty the read pipeline
    logic [BEAT_W-1:0] beat;   // low address bits for this edge
  } sramStrobes_t;

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BEAT_W-1:0] addrLow,
  input  logic              ceN,
  input  logic              adscN,
  input  logic              adspN,
  input  logic              advN,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              zz,
  output sramStrobes_t      st,
  output logic [LANES-1:0]  wrLanes
);

  logic              active, nextActive;
  logic [BEAT_W-1:0] cnt, nextCnt;
  logic [LANES-1:0]  reqLanes;
  logic              anyWr;
  logic              ctlStart, procStart, contCycle;

  always_comb begin
    if (!gwN)       reqLanes = '1;
    else if (!bweN) reqLanes = ~bwN;
    else            reqLanes = '0;
  end
  assign anyWr = |reqLanes;

  assign ctlStart  = !zz && !adscN;
  assign procStart = !zz && adscN && !adspN && !ceN;
  assign contCycle = !zz && adscN && !procStart && active;

  always_comb begin
    st         = '0;
    nextActive = active;
    nextCnt    = cnt;
    if (zz) begin
      st.flush   = 1'b1;
      nextActive = 1'b0;
    end else if (ctlStart) begin
      if (ceN) begin
        nextActive = 1'b0;
      end else begin
        nextActive = 1'b1;
        st.load    = 1'b1;
        st.beat    = addrLow;
        nextCnt    = addrLow;
        st.wr      = anyWr;
        st.rd      = !anyWr;
      end
    end else if (procStart) begin
      nextActive = 1'b1;
      st.load    = 1'b1;
      st.beat    = addrLow;
      nextCnt    = addrLow;
      st.rd      = 1'b1;
    end else if (active) begin
      st.beat = advN ? cnt : cnt + 1'b1;
      nextCnt = st.beat;
      st.wr   = anyWr;
      st.rd   = !anyWr;
    end
  end

  assign wrLanes = st.wr ? reqLanes : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      active <= nextActive;
      cnt    <= nextCnt;
    end
  end

  // R10: sleep blocks every access
  p_sleep_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    zz |-> (!st.rd && !st.wr && wrLanes == '0));

  // R5: processor-strobe start never writes on its own edge
  p_proc_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!zz && adscN && !adspN && !ceN) |-> (st.rd && !st.wr));

  // R2: advance steps the counter modulo 4
  p_advance_r2: assert property (@(posedge clk) disable iff (!rstN)
    (contCycle && !advN) |=> (cnt == $past(cnt) + 2'd1));

  // R6: suspend holds the counter
  p_suspend_r6: assert property (@(posedge clk) disable iff (!rstN)
    (contCycle && advN) |=> $stable(cnt));

  // R8: deselect leaves no access open on the next edge
  p_deselect_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!zz && !adscN && ceN) |=> !active);

endmodule

// File: rtl/burst_sram_dp.sv
module burst_sram_dp
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  sramStrobes_t             st,
  input  logic [LANES-1:0]         wrLanes,
  input  logic [ADDR_W-BEAT_W-1:0] addrHi,
  input  logic [DATA_W-1:0]        dqIn,
  input  logic                     oeN,
  input  logic                     zz,
  output logic [DATA_W-1:0]        dqOut,
  output logic                     dqOe
);

  localparam int LANE_W = DATA_W / LANES;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HI_W   = ADDR_W - BEAT_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [HI_W-1:0]   baseHi;
  logic [ADDR_W-1:0] opAddr;
  logic [ADDR_W-1:0] pendAddr;
  logic              readPend;
  logic              qValid;
  logic [DATA_W-1:0] qReg;

  assign opAddr = {(st.load ? addrHi : baseHi), st.beat};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHi   <= '0;
      readPend <= 1'b0;
      qValid   <= 1'b0;
      pendAddr <= '0;
    end else begin
      if (st.load) baseHi <= addrHi;
      if (st.flush) begin
        readPend <= 1'b0;
        qValid   <= 1'b0;
      end else begin
        qValid   <= readPend;
        readPend <= st.rd;
        if (st.rd) pendAddr <= opAddr;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (wrLanes[i]) mem[opAddr][i*LANE_W +: LANE_W] <= dqIn[i*LANE_W +: LANE_W];
    end
    if (readPend && !st.flush) qReg <= mem[pendAddr];
  end

  assign dqOut = qReg;
  assign dqOe  = qValid && !oeN && !zz;

  // R4: output enable high keeps the drivers off
  p_oe_hiz_r4: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !dqOe);

  // R9: a write cycle leaves the bus released two edges on
  p_after_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.wr |-> ##2 !dqOe);

  // R10: sleep edge empties the output stage
  p_sleep_flush_r10: assert property (@(posedge clk) disable iff (!rstN)
    st.flush |=> !dqOe);

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN,
  input  logic              adscN,
  input  logic              adspN,
  input  logic              advN,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              oeN,
  input  logic              zz,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe
);

  sramStrobes_t     st;
  logic [LANES-1:0] wrLanes;

  burst_sram_ctrl #(.LANES(LANES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .addrLow (addr[BEAT_W-1:0]),
    .ceN     (ceN),
    .adscN   (adscN),
    .adspN   (adspN),
    .advN    (advN),
    .gwN     (gwN),
    .bweN    (bweN),
    .bwN     (bwN),
    .zz      (zz),
    .st      (st),
    .wrLanes (wrLanes)
  );

  burst_sram_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .wrLanes (wrLanes),
    .addrHi  (addr[ADDR_W-1:BEAT_W]),
    .dqIn    (dqIn),
    .oeN     (oeN),
    .zz      (zz),
    .dqOut   (dqOut),
    .dqOe    (dqOe)
  );

endmodule

// File: tb/burst_sram_tb.sv
`timescale 1ns/1ps
module burst_sram_tb;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int LANES  = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN;
  logic [ADDR_W-1:0] addr;
  logic              ceN, adscN, adspN, advN, gwN, bweN, oeN, zz;
  logic [LANES-1:0]  bwN;
  logic [DATA_W-1:0] dqIn;
  logic [DATA_W-1:0] dqOut;
  logic              dqOe;

  int nChecks = 0;
  int nErrors = 0;

  always #2 clk = ~clk;

  burst_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .adscN(adscN), .adspN(adspN),
    .advN(advN), .gwN(gwN), .bweN(bweN), .bwN(bwN), .oeN(oeN), .zz(zz),
    .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

  // Reference model state
  logic [DATA_W-1:0] refMem [DEPTH];
  logic              mActive, mPend, mQValid;
  logic [ADDR_W-1:0] mBase, mPendAddr;
  logic [1:0]        mCnt;
  logic [DATA_W-1:0] mQData;

  function automatic logic [LANES-1:0] reqLanes();
    if (!gwN)  return '1;
    if (!bweN) return ~bwN;
    return '0;
  endfunction

  // Predict the effect of the coming rising edge from the driven inputs
  task automatic modelStep();
    logic [LANES-1:0]  ln = reqLanes();
    logic              doRd = 1'b0, doWr = 1'b0;
    logic [ADDR_W-1:0] a = '0;
    if (zz) begin
      mActive = 1'b0; mPend = 1'b0; mQValid = 1'b0;
      return;
    end
    if (!adscN) begin
      if (ceN) mActive = 1'b0;
      else begin
        mActive = 1'b1; mBase = addr; mCnt = addr[1:0]; a = addr;
        doWr = (ln != 0); doRd = (ln == 0);
      end
    end else if (!adspN && !ceN) begin
      mActive = 1'b1; mBase = addr; mCnt = addr[1:0]; a = addr; doRd = 1'b1;
    end else if (mActive) begin
      if (!advN) mCnt = mCnt + 2'd1;
      a = {mBase[ADDR_W-1:2], mCnt};
      doWr = (ln != 0); doRd = (ln == 0);
    end
    mQValid = mPend;
    if (mPend) mQData = refMem[mPendAddr];
    if (doWr)
      for (int i = 0; i < LANES; i++)
        if (ln[i]) refMem[a][i*8 +: 8] = dqIn[i*8 +: 8];
    mPend = doRd;
    if (doRd) mPendAddr = a;
  endtask

  task automatic checkOut(string tag);
    logic expOe = mQValid && !oeN && !zz;
    nChecks++;
    if (dqOe !== expOe) begin
      nErrors++;
      $display("FAIL %s dqOe actual %0b expected %0b at %0t", tag, dqOe, expOe, $time);
    end
    if (mQValid) begin
      nChecks++;
      if (dqOut !== mQData) begin
        nErrors++;
        $display("FAIL %s dqOut actual %h expected %h at %0t", tag, dqOut, mQData, $time);
      end
    end
  endtask

  // Inputs are set at a falling edge; one rising edge follows, then check
  task automatic cyc(string tag);
    modelStep();
    @(posedge clk);
    #1;
    checkOut(tag);
    @(negedge clk);
  endtask

  task automatic setIdle();
    ceN = 0; adscN = 1; adspN = 1; advN = 1; gwN = 1; bweN = 1;
    bwN = '1; oeN = 0; zz = 0; addr = '0; dqIn = '0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL R3 watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] seedVal;
    seedVal = $urandom(32'h1d2c3b4a);
    rstN = 0;
    setIdle();
    mActive = 0; mPend = 0; mQValid = 0; mBase = '0; mPendAddr = '0; mCnt = '0; mQData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    nChecks++;
    if (dqOe !== 1'b0) begin
      nErrors++;
      $display("FAIL R11 dqOe actual %0b expected 0", dqOe);
    end
    rstN = 1;
    // R11: first edges with no strobe open no access, bus stays off
    cyc("R11"); cyc("R11");

    // Fill the whole array with controller-strobe bursts (R1 full writes, R2 stepping)
    for (int b = 0; b < DEPTH / 4; b++) begin
      addr = ADDR_W'(b * 4); adscN = 0; advN = 1; gwN = 0; dqIn = $urandom;
      cyc("R1");
      adscN = 1; advN = 0;
      for (int k = 0; k < 3; k++) begin dqIn = $urandom; cyc("R2"); end
    end
    setIdle(); ceN = 1;
    adscN = 0; cyc("R8");
    adscN = 1; cyc("R9"); cyc("R9");

    // R2: wrapping burst write from low value 2 then wrapping read
    ceN = 0; addr = 10'h012; adscN = 0; gwN = 0; dqIn = 32'hA0A0_0002; cyc("R2");
    adscN = 1; advN = 0;
    dqIn = 32'hA0A0_0003; cyc("R2");
    dqIn = 32'hA0A0_0000; cyc("R2");
    dqIn = 32'hA0A0_0001; cyc("R2");
    gwN = 1; advN = 1; addr = 10'h012; adspN = 0; cyc("R3");
    adspN = 1; advN = 0; cyc("R3"); cyc("R2"); cyc("R2"); cyc("R2");
    // R6: suspend repeats the current word
    advN = 1; cyc("R6"); cyc("R6"); cyc("R6");
    // R4: drivers off at once when oeN rises
    oeN = 1; #0.5;
    nChecks++;
    if (dqOe !== 1'b0) begin
      nErrors++;
      $display("FAIL R4 dqOe actual %0b expected 0", dqOe);
    end
    cyc("R4"); oeN = 0; cyc("R4");

    // R1: full write then partial byte write at 0x40, read back
    addr = 10'h040; adscN = 0; gwN = 0; dqIn = 32'h1122_3344; cyc("R1");
    gwN = 1; bweN = 0; bwN = 4'b1010; dqIn = 32'hAABB_CCDD; cyc("R1");
    bweN = 0; bwN = 4'b1111; cyc("R1");
    bweN = 1; cyc("R1"); cyc("R1"); cyc("R1");
    // R9: write with reads before and after
    adscN = 1; advN = 1; gwN = 0; dqIn = 32'h5555_AAAA; cyc("R9");
    gwN = 1; cyc("R9"); cyc("R9"); cyc("R9");

    // R5: processor strobe with write enables still reads on its edge
    addr = 10'h080; adscN = 1; adspN = 0; gwN = 0; dqIn = 32'hDEAD_BEEF; cyc("R5");
    adspN = 1; advN = 1; dqIn = 32'hCAFE_F00D; cyc("R5");
    gwN = 1; adscN = 0; cyc("R5"); adscN = 1; cyc("R5"); cyc("R5");

    // R7: both strobes low, controller write wins; processor ignored when disabled
    addr = 10'h0C1; adscN = 0; adspN = 0; gwN = 0; dqIn = 32'h0BAD_0C11; cyc("R7");
    gwN = 1; adscN = 1; adspN = 0; ceN = 1; addr = 10'h200; advN = 0; cyc("R7");
    adspN = 1; ceN = 0; cyc("R7"); cyc("R7"); cyc("R7");
    adscN = 0; addr = 10'h301; cyc("R7"); adscN = 1; cyc("R7"); cyc("R7");

    // R8: deselect mid-read
    adscN = 0; ceN = 1; cyc("R8");
    adscN = 1; ceN = 0; advN = 0; gwN = 0; cyc("R8"); cyc("R8"); cyc("R8");
    gwN = 1;

    // R10: sleep during a read stream
    adscN = 0; addr = 10'h012; cyc("R10"); adscN = 1; advN = 0; cyc("R10");
    zz = 1; cyc("R10"); cyc("R10");
    zz = 0; cyc("R10"); cyc("R10");
    adspN = 0; cyc("R10"); adspN = 1; cyc("R10"); cyc("R10");

    // Constrained random phase (R3 and all others through the model)
    for (int n = 0; n < 3000; n++) begin
      ceN   = ($urandom % 8) == 0;
      adscN = ($urandom % 6) != 0;
      adspN = ($urandom % 6) != 0;
      advN  = ($urandom % 3) == 0;
      gwN   = ($urandom % 4) != 0;
      bweN  = ($urandom % 2) != 0;
      bwN   = LANES'($urandom);
      oeN   = ($urandom % 10) == 0;
      zz    = ($urandom % 40) == 0;
      addr  = ADDR_W'($urandom);
      dqIn  = $urandom;
      cyc("R3");
    end

    summary();
    $finish;
  end

endmodule